// File: doc/BRIEF.md
# Hibernation Wakeup Power Controller

This block lives in the battery-backed domain, which stays powered. It drives a regulator enable output that switches the main core supply. Software enables the regulator-control pin function and writes a start bit. The block then turns the core supply off on the next clock edge. The supply comes back when a real-time-clock alarm event or an external wakeup pin edge arrives.

The block keeps three sticky status flags: battery-domain power-on, alarm seen and wakeup seen. After the core reboots, software reads them to tell a return from hibernation apart from a cold start. Each flag is cleared by writing 1 to its bit. The RTC counter, the alarm comparator and the analog switching are outside the block and reach it as inputs.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, `vreg_en_o` is 1, the pin-function register (address 1) reads 0x00 and the status register (address 2) reads 0x01. In the status register, bit 0 is the power-on flag, bit 1 the alarm flag and bit 2 the wakeup flag.
- R2: A write of bit 0 = 1 to the control register (address 0) starts hibernation when all of these hold: pin-function bit 0 (regulator control) is 1, the alarm and wakeup flags are clear, and no wake event is present in that cycle. `vreg_en_o` then reads 0 after that clock edge.
- R3: A start write made while the alarm flag or the wakeup flag is set is ignored, and `vreg_en_o` stays 1.
- R4: While pin-function bit 0 is 0, `vreg_en_o` is 1 and start writes have no effect.
- R5: A high `alarm_evt_i` sets the alarm flag. During hibernation it also drives `vreg_en_o` to 1 after the same clock edge.
- R6: `wake_pin_i` passes through a two-flop synchronizer and a rising-edge detector. When pin-function bit 1 (wakeup pin) is 1, a pin rise sets the wakeup flag and ends hibernation on the third clock edge after the rise. A pin held high triggers only once. When the bit is 0, the pin is ignored.
- R7: Status flags clear only when software writes 1 to their bit. Writing 0 has no effect. A flag set event in the same cycle as its clear wins over the clear.
- R8: The flags stay set across hibernation. The power-on flag is set only by reset, so after an alarm wake with the power-on flag uncleared, status reads 0x03.
- R9: When no wake source is enabled and no alarm arrives, hibernation lasts indefinitely. This holds whatever the pin does.
- R10: The pin-function register reads back the written bits 1:0. The control register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Battery-domain clock |
| rst_ni | input | 1 | Active-low asynchronous battery-domain reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW (2) | Register address |
| bus_wdata_i | input | DW (8) | Write data |
| bus_rdata_o | output | DW (8) | Read data for `bus_addr_i`, combinational |
| alarm_evt_i | input | 1 | RTC alarm coincidence event |
| wake_pin_i | input | 1 | Asynchronous external wakeup pin |
| vreg_en_o | output | 1 | Regulator enable; 0 turns the core supply off |

## Verification
Every cycle, the bound checker confirms the following: an accepted start drops the regulator enable, and a blocked start leaves it high. Either wake event raises the enable and sets its flag. A disabled regulator-pin function forces the enable high. The alarm flag only rises after an alarm event, and the power-on flag survives anything but a write of 1. Some behaviour shows only in the bench's scenarios: the exact synchronizer latency of the pin, the single trigger of a held pin, the ignored pin when its function is off, read-back values, and the indefinite off state with no source configured.

// File: rtl/hib_pkg.sv
package hib_pkg;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_PINFN = 1;
  localparam int unsigned ADDR_STAT  = 2;

  localparam int unsigned BIT_START  = 0;
  localparam int unsigned BIT_REG_EN = 0;
  localparam int unsigned BIT_WK_EN  = 1;
  localparam int unsigned BIT_PON    = 0;
  localparam int unsigned BIT_ALARM  = 1;
  localparam int unsigned BIT_WKUP   = 2;

  typedef enum logic {ST_RUN = 1'b0, ST_HIB = 1'b1} hib_state_e;
endpackage

// File: rtl/hib_pin_sync.sv
module hib_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  localparam int unsigned W = STAGES + 1;
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[W-2:0], pin_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hib_regs.sv
module hib_regs
  import hib_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          alarm_evt_i,
  input  logic          pin_rise_i,
  output logic          wake_evt_o,
  output logic          start_req_o,
  output logic          reg_en_o,
  output logic          pon_flag_o,
  output logic          alarm_flag_o,
  output logic          wkup_flag_o
);
  logic wr_ctrl, wr_pinfn, wr_stat;
  logic wk_en_q;

  assign wr_ctrl  = we_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_pinfn = we_i && (addr_i == AW'(ADDR_PINFN));
  assign wr_stat  = we_i && (addr_i == AW'(ADDR_STAT));

  assign start_req_o = wr_ctrl && wdata_i[BIT_START];
  assign wake_evt_o  = pin_rise_i && wk_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_en_o <= 1'b0;
      wk_en_q  <= 1'b0;
    end else if (wr_pinfn) begin
      reg_en_o <= wdata_i[BIT_REG_EN];
      wk_en_q  <= wdata_i[BIT_WK_EN];
    end
  end

  // set has priority over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pon_flag_o   <= 1'b1;
      alarm_flag_o <= 1'b0;
      wkup_flag_o  <= 1'b0;
    end else begin
      if (wr_stat && wdata_i[BIT_PON]) pon_flag_o <= 1'b0;
      if (alarm_evt_i)                        alarm_flag_o <= 1'b1;
      else if (wr_stat && wdata_i[BIT_ALARM]) alarm_flag_o <= 1'b0;
      if (wake_evt_o)                         wkup_flag_o <= 1'b1;
      else if (wr_stat && wdata_i[BIT_WKUP])  wkup_flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(ADDR_PINFN): begin
        rdata_o[BIT_REG_EN] = reg_en_o;
        rdata_o[BIT_WK_EN]  = wk_en_q;
      end
      AW'(ADDR_STAT): begin
        rdata_o[BIT_PON]   = pon_flag_o;
        rdata_o[BIT_ALARM] = alarm_flag_o;
        rdata_o[BIT_WKUP]  = wkup_flag_o;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic reg_en_i,
  input  logic alarm_flag_i,
  input  logic wkup_flag_i,
  input  logic alarm_evt_i,
  input  logic wake_evt_i,
  output logic vreg_en_o
);
  hib_state_e state_q, state_d;
  logic go, wake;

  assign wake = alarm_evt_i || wake_evt_i;
  assign go   = start_req_i && reg_en_i && !alarm_flag_i && !wkup_flag_i && !wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: if (go)   state_d = ST_HIB;
      ST_HIB: if (wake) state_d = ST_RUN;
      default:          state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign vreg_en_o = !((state_q == ST_HIB) && reg_en_i);
endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl #(
  parameter int unsigned AW          = 2,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          alarm_evt_i,
  input  logic          wake_pin_i,
  output logic          vreg_en_o
);
  logic pin_rise, wake_evt, start_req, reg_en;
  logic pon_flag, alarm_flag, wkup_flag;

  hib_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(wake_pin_i), .rise_o(pin_rise)
  );

  hib_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .alarm_evt_i (alarm_evt_i),
    .pin_rise_i  (pin_rise),
    .wake_evt_o  (wake_evt),
    .start_req_o (start_req),
    .reg_en_o    (reg_en),
    .pon_flag_o  (pon_flag),
    .alarm_flag_o(alarm_flag),
    .wkup_flag_o (wkup_flag)
  );

  hib_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_req_i (start_req),
    .reg_en_i    (reg_en),
    .alarm_flag_i(alarm_flag),
    .wkup_flag_i (wkup_flag),
    .alarm_evt_i (alarm_evt_i),
    .wake_evt_i  (wake_evt),
    .vreg_en_o   (vreg_en_o)
  );
endmodule

// File: rtl/hib_wake_ctrl_chk.sv
module hib_wake_ctrl_chk #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic          alarm_evt_i,
  input logic          vreg_en_o,
  input logic          reg_en,
  input logic          pon_flag,
  input logic          alarm_flag,
  input logic          wkup_flag,
  input logic          wake_evt
);
  logic start_wr, stat_clr_pon;
  assign start_wr     = bus_we_i && (bus_addr_i == AW'(0)) && bus_wdata_i[0];
  assign stat_clr_pon = bus_we_i && (bus_addr_i == AW'(2)) && bus_wdata_i[0];

  a_r2_start_drops_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr && reg_en && !alarm_flag && !wkup_flag && !alarm_evt_i && !wake_evt)
      |=> !vreg_en_o);

  a_r3_flags_block_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr && (alarm_flag || wkup_flag) && vreg_en_o) |=> vreg_en_o);

  a_r4_fn_off_keeps_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en |-> vreg_en_o);

  a_r5_alarm_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_evt_i |=> (vreg_en_o && alarm_flag));

  a_r6_pin_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt |=> (vreg_en_o && wkup_flag));

  a_r7_alarm_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag) |-> $past(alarm_evt_i));

  a_r8_pon_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pon_flag && !stat_clr_pon) |=> pon_flag);
endmodule

bind hib_wake_ctrl hib_wake_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .alarm_evt_i(alarm_evt_i),
  .vreg_en_o  (vreg_en_o),
  .reg_en     (reg_en),
  .pon_flag   (pon_flag),
  .alarm_flag (alarm_flag),
  .wkup_flag  (wkup_flag),
  .wake_evt   (wake_evt)
);

// File: tb/tb_hib_wake_ctrl.sv
module tb_hib_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm = 1'b0;
  logic       pin = 1'b0;
  logic       vreg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hib_wake_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .alarm_evt_i(alarm),
    .wake_pin_i(pin), .vreg_en_o(vreg)
  );

  // {req[3:0], we, addr[1:0], wdata[7:0], alarm, pin, exp_vreg, exp_rd[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {4'd1,  1'b0, 2'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'h01}, // R1 status after reset
    {4'd7,  1'b1, 2'd2, 8'h01, 1'b0, 1'b0, 1'b1, 8'h00}, // R7 clear pon
    {4'd4,  1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b1, 8'h00}, // R4 start, fn off
    {4'd10, 1'b1, 2'd1, 8'h03, 1'b0, 1'b0, 1'b1, 8'h03}, // R10 enable both
    {4'd2,  1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 enter
    {4'd5,  1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 1'b1, 8'h02}, // R5 alarm wake
    {4'd3,  1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b1, 8'h00}, // R3 blocked
    {4'd7,  1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'h02}, // R7 write 0
    {4'd7,  1'b1, 2'd2, 8'h02, 1'b1, 1'b0, 1'b1, 8'h02}, // R7 set wins
    {4'd7,  1'b1, 2'd2, 8'h02, 1'b0, 1'b0, 1'b1, 8'h00}, // R7 clear
    {4'd2,  1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 enter
    {4'd6,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R6 pin rise
    {4'd6,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'd6,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b1, 8'h04}, // R6 third edge
    {4'd6,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b1, 8'h04},
    {4'd6,  1'b1, 2'd2, 8'h04, 1'b0, 1'b1, 1'b1, 8'h00}, // R6 held pin
    {4'd6,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // R6 no retrigger
    {4'd10, 1'b1, 2'd1, 8'h01, 1'b0, 1'b0, 1'b1, 8'h01}, // R10 pin fn off
    {4'd2,  1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 enter
    {4'd9,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R9 pin ignored
    {4'd9,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'd9,  1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'd9,  1'b0, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd9,  1'b0, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd9,  1'b0, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic al, input logic p);
    @(negedge clk);
    we = w; addr = a; wdata = d; alarm = al; pin = p;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a);
    @(negedge clk);
    we = 1'b0; addr = a; alarm = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][21], VEC[i][20:19], VEC[i][18:11], VEC[i][10], VEC[i][9]);
      chk($sformatf("R%0d", VEC[i][25:22]), $sformatf("vec %0d vreg", i),
          {7'b0, vreg}, {7'b0, VEC[i][8]});
      chk($sformatf("R%0d", VEC[i][25:22]), $sformatf("vec %0d rdata", i),
          rdata, VEC[i][7:0]);
    end

    // R1: reset in the middle of hibernation
    @(negedge clk) rst_ni = 1'b0;
    #1;
    chk("R1", "vreg in reset", {7'b0, vreg}, 8'h01);
    @(negedge clk) rst_ni = 1'b1;
    peek(2'd1);
    chk("R1", "pinfn after reset", rdata, 8'h00);
    peek(2'd2);
    chk("R1", "status after reset", rdata, 8'h01);

    // R8: power-on flag kept across hibernation, alarm wake adds its flag
    cyc(1'b1, 2'd1, 8'h01, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 8'h01, 1'b0, 1'b0);
    chk("R8", "off with pon set", {7'b0, vreg}, 8'h00);
    cyc(1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
    chk("R8", "alarm wake vreg", {7'b0, vreg}, 8'h01);
    chk("R8", "sticky status", rdata, 8'h03);

    // R4: fn disabled while hibernating releases supply
    cyc(1'b1, 2'd2, 8'h02, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 8'h01, 1'b0, 1'b0);
    chk("R2", "re-enter", {7'b0, vreg}, 8'h00);
    cyc(1'b1, 2'd1, 8'h00, 1'b0, 1'b0);
    chk("R4", "fn off forces on", {7'b0, vreg}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule